// File: doc/BRIEF.md
# Register Window Rotation Controller

This block tracks which slice of a circular physical register file a processor sees as its current register window. The position of the slice is a base counter in steps of four registers. A live-frame mask holds one bit per four-register group and marks the groups that still belong to an active caller. The register data path lives elsewhere. This controller only decides where the window moves, whether the move is legal, and whether a frame has to be spilled or refilled first.

Three operations are supported. A call entry moves the window forward by the caller's increment and marks the new frame live. A windowed return moves the window back by the frame size held in the two top bits of the return address. A plain rotate adds a signed 4-bit step. To find the nearest live frame, a call scans the mask circularly from the group after the base. A return probes the three groups below the base. These scans detect window overflow and underflow and choose the 4-, 8- or 12-register spill or fill kind.

The request side is a valid-in / done-out pair. The controller accepts an operation in every cycle that `in_valid` is high and never applies back-pressure, so it has no ready signal. Each result is reported once, in the cycle after acceptance, with `done` high. Back-to-back requests are allowed.

Top module: `wrf_ctrl`

## Requirements
- R1: After reset the base is 0, the live mask has only bit 0 set, the saved old base and exception PC are 0, and `done` is low.
- R2: Operation codes are 0 for call entry, 1 for return, 2 for rotate and 3 reserved. Each cycle with `in_valid` high accepts one operation, and `done` is high in exactly the next cycle. `done` is low after a cycle with no request.
- R3: A call entry is illegal if its register operand is above 3, if the window-enable input is low, or if the exception-mode input is high. The reserved code is always illegal. An illegal operation leaves the base, mask, old base and exception PC unchanged, reports exception code 0 and a return PC of 0.
- R4: A return is illegal if its frame size n (return address bits 31:30) is 0, if the window-enable input is low, or if the exception-mode input is high. The bits at base-1, base-2 and base-3 are probed in that order, and the first set bit gives m = 1, 2 or 3 (0 if none is set). The return is also illegal if m is nonzero and differs from n.
- R5: A call entry whose increment c (0 to 3) covers no live group among the first c groups after the base moves the base by c, modulo the group count, and sets the mask bit of the new base.
- R6: A call entry whose first c groups after the base hold a live group raises an overflow. The base advances by the distance to the nearest live group, and the mask is unchanged. The count of clear groups that follow that live group selects the code: 0 gives 1 (spill 4), 1 gives 2 (spill 8), 2 or more gives 3 (spill 12).
- R7: A legal return reports a return PC made of PC bits 31:30 and return-address bits 29:0, and moves the base back by n. If the group at the new base is live, it clears the mask bit of the old base and reports code 0.
- R8: A legal return whose new base group is not live keeps the moved base and the unchanged mask, and reports underflow code 4+n (5, 6 or 7).
- R9: A rotate adds its signed 4-bit step to the base modulo the group count. It never touches the mask and is never illegal.
- R10: An overflow or underflow saves the pre-operation base as the old base and the request PC as the exception PC. Every other outcome leaves both unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request, accepted every cycle it is high |
| op | input | 2 | Operation code (0 call, 1 return, 2 rotate, 3 reserved) |
| reg_sel | input | 4 | Register operand of a call entry |
| call_inc | input | 2 | Call increment from the status word |
| woe | input | 1 | Window operations enabled |
| excm | input | 1 | Exception mode active |
| rot_imm | input | 4 | Signed rotate step |
| ret_addr | input | 32 | Return address; bits 31:30 carry the frame size |
| pc | input | 32 | PC of the operation |
| done | output | 1 | Result valid, one cycle after acceptance |
| illegal | output | 1 | Operation was illegal |
| exc_code | output | 3 | 0 none, 1/2/3 overflow 4/8/12, 5/6/7 underflow 4/8/12 |
| ret_pc | output | 32 | Return target of a legal return, else 0 |
| exc_pc | output | 32 | PC saved on the last window exception |
| old_base | output | BW | Base saved on the last window exception |
| win_base | output | BW | Current window base |
| live_mask | output | GROUPS | Live-frame mask |

## Verification
All results of an accepted operation appear one clock edge after the edge that accepts it: `done`, `illegal`, `exc_code` and `ret_pc`, and also the updated base, mask, old base and exception PC. The bench drives each request half a cycle before the accepting edge and samples every output at the next falling edge. The following request is driven at that same falling edge, so operations run back to back and each result is read in the one cycle in which it is due. A final idle cycle checks that `done` falls and that the state holds.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  typedef enum logic [1:0] {
    OP_CALL = 2'd0,
    OP_RET  = 2'd1,
    OP_ROT  = 2'd2,
    OP_RSVD = 2'd3
  } wrf_op_e;

  typedef enum logic [2:0] {
    WX_NONE  = 3'd0,
    WX_OVF4  = 3'd1,
    WX_OVF8  = 3'd2,
    WX_OVF12 = 3'd3,
    WX_RSV4  = 3'd4,
    WX_UNF4  = 3'd5,
    WX_UNF8  = 3'd6,
    WX_UNF12 = 3'd7
  } wrf_exc_e;

endpackage

// File: rtl/wrf_call_scan.sv
module wrf_call_scan
  import wrf_pkg::*;
#(
  parameter int GROUPS = 16,
  parameter int BW     = 4
) (
  input  logic [BW-1:0]     base,
  input  logic [GROUPS-1:0] mask,
  input  logic [1:0]        inc,
  output logic              spill,
  output logic [BW-1:0]     spill_base,
  output wrf_exc_e          spill_kind,
  output logic [BW-1:0]     plain_base,
  output logic [GROUPS-1:0] plain_mask
);
  localparam int CW = BW + 1;

  // ahead[k] is the group k+1 places past the base, wrapping around the file
  logic [GROUPS-1:0] ahead;
  for (genvar k = 0; k < GROUPS; k++) begin : g_rot
    assign ahead[k] = mask[base + BW'(k + 1)];
  end

  function automatic logic [CW-1:0] tz(input logic [GROUPS-1:0] v);
    logic [CW-1:0] r;
    r = CW'(GROUPS);
    for (int i = GROUPS - 1; i >= 0; i--) begin
      if (v[i]) r = CW'(i);
    end
    return r;
  endfunction

  logic [2:0]        inc_bits;
  logic [CW-1:0]     first_tz;
  logic [CW-1:0]     step;
  logic [GROUPS-1:0] rest;
  logic [CW-1:0]     rest_tz;

  always_comb begin
    case (inc)
      2'd0:    inc_bits = 3'b000;
      2'd1:    inc_bits = 3'b001;
      2'd2:    inc_bits = 3'b011;
      default: inc_bits = 3'b111;
    endcase
  end

  assign spill      = |(ahead[2:0] & inc_bits);
  assign first_tz   = tz(ahead);
  assign step       = first_tz + CW'(1);
  assign spill_base = base + BW'(step);
  assign rest       = ahead >> step;
  assign rest_tz    = tz(rest);

  always_comb begin
    if (rest_tz == '0)              spill_kind = WX_OVF4;
    else if (rest_tz == CW'(1))     spill_kind = WX_OVF8;
    else                            spill_kind = WX_OVF12;
  end

  assign plain_base = base + BW'(inc);
  assign plain_mask = mask | (GROUPS'(1) << plain_base);

endmodule

// File: rtl/wrf_ret_scan.sv
module wrf_ret_scan #(
  parameter int GROUPS = 16,
  parameter int BW     = 4
) (
  input  logic [BW-1:0]     base,
  input  logic [GROUPS-1:0] mask,
  input  logic [1:0]        frame,
  output logic [1:0]        found,
  output logic [BW-1:0]     new_base,
  output logic              hit,
  output logic [GROUPS-1:0] freed_mask
);
  // nearest live caller below the base, closest group first
  always_comb begin
    if (mask[base - BW'(1)])      found = 2'd1;
    else if (mask[base - BW'(2)]) found = 2'd2;
    else if (mask[base - BW'(3)]) found = 2'd3;
    else                          found = 2'd0;
  end

  assign new_base   = base - BW'(frame);
  assign hit        = mask[new_base];
  assign freed_mask = mask & ~(GROUPS'(1) << base);

endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
  import wrf_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int ADDR_W   = 32,
  localparam int GROUPS  = NUM_REGS / 4,
  localparam int BW      = $clog2(GROUPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [3:0]        reg_sel,
  input  logic [1:0]        call_inc,
  input  logic              woe,
  input  logic              excm,
  input  logic [3:0]        rot_imm,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [ADDR_W-1:0] pc,
  output logic              done,
  output logic              illegal,
  output logic [2:0]        exc_code,
  output logic [ADDR_W-1:0] ret_pc,
  output logic [ADDR_W-1:0] exc_pc,
  output logic [BW-1:0]     old_base,
  output logic [BW-1:0]     win_base,
  output logic [GROUPS-1:0] live_mask
);
  logic              c_spill;
  logic [BW-1:0]     c_spill_base, c_plain_base;
  wrf_exc_e          c_kind;
  logic [GROUPS-1:0] c_plain_mask;

  wrf_call_scan #(.GROUPS(GROUPS), .BW(BW)) u_call (
    .base(win_base), .mask(live_mask), .inc(call_inc),
    .spill(c_spill), .spill_base(c_spill_base), .spill_kind(c_kind),
    .plain_base(c_plain_base), .plain_mask(c_plain_mask)
  );

  logic [1:0]        frame, r_found;
  logic [BW-1:0]     r_base;
  logic              r_hit;
  logic [GROUPS-1:0] r_mask;

  assign frame = ret_addr[ADDR_W-1 -: 2];

  wrf_ret_scan #(.GROUPS(GROUPS), .BW(BW)) u_ret (
    .base(win_base), .mask(live_mask), .frame(frame),
    .found(r_found), .new_base(r_base), .hit(r_hit), .freed_mask(r_mask)
  );

  logic              mode_ok;
  logic [BW-1:0]     rot_step;
  logic [BW-1:0]     nx_base;
  logic [GROUPS-1:0] nx_mask;
  logic              nx_ill, nx_wexc;
  wrf_exc_e          nx_exc;
  logic [ADDR_W-1:0] nx_ret;

  assign mode_ok  = woe & ~excm;
  assign rot_step = BW'(signed'(rot_imm));

  always_comb begin
    nx_base = win_base;
    nx_mask = live_mask;
    nx_ill  = 1'b0;
    nx_wexc = 1'b0;
    nx_exc  = WX_NONE;
    nx_ret  = '0;
    case (wrf_op_e'(op))
      OP_CALL: begin
        if (reg_sel > 4'd3 || !mode_ok) begin
          nx_ill = 1'b1;
        end else if (c_spill) begin
          nx_base = c_spill_base;
          nx_exc  = c_kind;
          nx_wexc = 1'b1;
        end else begin
          nx_base = c_plain_base;
          nx_mask = c_plain_mask;
        end
      end
      OP_RET: begin
        if (frame == 2'd0 || (r_found != 2'd0 && r_found != frame) || !mode_ok) begin
          nx_ill = 1'b1;
        end else begin
          nx_ret  = {pc[ADDR_W-1 -: 2], ret_addr[ADDR_W-3:0]};
          nx_base = r_base;
          if (r_hit) begin
            nx_mask = r_mask;
          end else begin
            nx_exc  = wrf_exc_e'({1'b1, frame});
            nx_wexc = 1'b1;
          end
        end
      end
      OP_ROT: nx_base = win_base + rot_step;
      default: nx_ill = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_base  <= '0;
      live_mask <= GROUPS'(1);
      old_base  <= '0;
      exc_pc    <= '0;
      done      <= 1'b0;
      illegal   <= 1'b0;
      exc_code  <= WX_NONE;
      ret_pc    <= '0;
    end else begin
      done <= in_valid;
      if (in_valid) begin
        win_base  <= nx_base;
        live_mask <= nx_mask;
        illegal   <= nx_ill;
        exc_code  <= nx_exc;
        ret_pc    <= nx_ret;
        if (nx_wexc) begin
          old_base <= win_base;
          exc_pc   <= pc;
        end
      end
    end
  end

endmodule

// File: rtl/wrf_ctrl_chk.sv
module wrf_ctrl_chk #(
  parameter int GROUPS = 16,
  parameter int BW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        op,
  input logic [3:0]        rot_imm,
  input logic              done,
  input logic              illegal,
  input logic [2:0]        exc_code,
  input logic [BW-1:0]     old_base,
  input logic [BW-1:0]     win_base,
  input logic [GROUPS-1:0] live_mask
);
  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done);

  // R3
  illegal_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd3) |=>
      (illegal && exc_code == 3'd0 && win_base == $past(win_base) &&
       live_mask == $past(live_mask)));

  // R9
  rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd2) |=>
      (!illegal && win_base == $past(win_base) + BW'(signed'($past(rot_imm))) &&
       live_mask == $past(live_mask)));

  // R8
  underflow_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd1) |=>
      (exc_code[2] |-> live_mask == $past(live_mask)));

  // R5
  call_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd0) |=>
      ((!illegal && exc_code == 3'd0) |-> live_mask[win_base]));

  // R10
  old_base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (exc_code == 3'd0 |-> old_base == $past(old_base)));
endmodule

bind wrf_ctrl wrf_ctrl_chk #(.GROUPS(GROUPS), .BW(BW)) u_wrf_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .rot_imm(rot_imm),
  .done(done), .illegal(illegal), .exc_code(exc_code), .old_base(old_base),
  .win_base(win_base), .live_mask(live_mask)
);

// File: tb/wrf_ctrl_test.sv
module wrf_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSTEP = 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0;
  logic [3:0]  reg_sel = '0;
  logic [1:0]  call_inc = '0;
  logic        woe = 1'b1;
  logic        excm = 1'b0;
  logic [3:0]  rot_imm = '0;
  logic [31:0] ret_addr = '0;
  logic [31:0] pc = '0;
  logic        done, illegal;
  logic [2:0]  exc_code;
  logic [31:0] ret_pc, exc_pc;
  logic [3:0]  old_base, win_base;
  logic [15:0] live_mask;

  int checks = 0;
  int errors = 0;

  wrf_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .reg_sel(reg_sel),
    .call_inc(call_inc), .woe(woe), .excm(excm), .rot_imm(rot_imm),
    .ret_addr(ret_addr), .pc(pc), .done(done), .illegal(illegal),
    .exc_code(exc_code), .ret_pc(ret_pc), .exc_pc(exc_pc), .old_base(old_base),
    .win_base(win_base), .live_mask(live_mask)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  sel;
    logic [1:0]  inc;
    logic        woe;
    logic        excm;
    logic [3:0]  imm;
    logic [31:0] ra;
    logic [31:0] pc;
    logic        e_ill;
    logic [2:0]  e_exc;
    logic [3:0]  e_base;
    logic [15:0] e_mask;
    logic [31:0] e_ret;
    logic [3:0]  e_owb;
    logic [31:0] e_epc;
  } step_t;

  // op sel inc woe excm imm ra pc | ill exc base mask ret owb epc
  localparam step_t STEPS [0:NSTEP-1] = '{
    '{2'd0,4'd1,2'd1,1'b1,1'b0,4'h0,32'h0,32'h0,          1'b0,3'd0,4'd1, 16'h0003,32'h0,4'd0, 32'h0},          // R5
    '{2'd1,4'd0,2'd0,1'b1,1'b0,4'h0,32'h4000_1234,32'h8000_0000,1'b0,3'd0,4'd0,16'h0001,32'h8000_1234,4'd0,32'h0}, // R7
    '{2'd0,4'd1,2'd2,1'b1,1'b0,4'h0,32'h0,32'h0,          1'b0,3'd0,4'd2, 16'h0005,32'h0,4'd0, 32'h0},          // R5
    '{2'd0,4'd1,2'd2,1'b1,1'b0,4'h0,32'h0,32'h0,          1'b0,3'd0,4'd4, 16'h0015,32'h0,4'd0, 32'h0},          // R5
    '{2'd2,4'd0,2'd0,1'b1,1'b0,4'hA,32'h0,32'h0,          1'b0,3'd0,4'd14,16'h0015,32'h0,4'd0, 32'h0},          // R9 wrap
    '{2'd0,4'd1,2'd2,1'b1,1'b0,4'h0,32'h0,32'h0000_0100,  1'b0,3'd2,4'd0, 16'h0015,32'h0,4'd14,32'h100},        // R6 spill 8, R10
    '{2'd2,4'd0,2'd0,1'b1,1'b0,4'h8,32'h0,32'h0,          1'b0,3'd0,4'd8, 16'h0015,32'h0,4'd14,32'h100},        // R9
    '{2'd1,4'd0,2'd0,1'b1,1'b0,4'h0,32'h8000_0000,32'h4000_0010,1'b0,3'd6,4'd6,16'h0015,32'h4000_0000,4'd8,32'h4000_0010}, // R8
    '{2'd1,4'd0,2'd0,1'b1,1'b0,4'h0,32'hC000_0000,32'h0,  1'b1,3'd0,4'd6, 16'h0015,32'h0,4'd8, 32'h4000_0010},  // R4 m!=n
    '{2'd1,4'd0,2'd0,1'b1,1'b0,4'h0,32'h0,32'h0,          1'b1,3'd0,4'd6, 16'h0015,32'h0,4'd8, 32'h4000_0010},  // R4 n=0
    '{2'd0,4'd1,2'd1,1'b0,1'b0,4'h0,32'h0,32'h0,          1'b1,3'd0,4'd6, 16'h0015,32'h0,4'd8, 32'h4000_0010},  // R3 woe
    '{2'd1,4'd0,2'd0,1'b1,1'b1,4'h0,32'h8000_0000,32'h0,  1'b1,3'd0,4'd6, 16'h0015,32'h0,4'd8, 32'h4000_0010},  // R4 excm
    '{2'd0,4'd4,2'd1,1'b1,1'b0,4'h0,32'h0,32'h0,          1'b1,3'd0,4'd6, 16'h0015,32'h0,4'd8, 32'h4000_0010},  // R3 operand
    '{2'd3,4'd0,2'd0,1'b1,1'b0,4'h0,32'h0,32'h0,          1'b1,3'd0,4'd6, 16'h0015,32'h0,4'd8, 32'h4000_0010},  // R3 reserved
    '{2'd0,4'd3,2'd0,1'b1,1'b0,4'h0,32'h0,32'h0,          1'b0,3'd0,4'd6, 16'h0055,32'h0,4'd8, 32'h4000_0010},  // R5 inc 0
    '{2'd1,4'd0,2'd0,1'b1,1'b0,4'h0,32'h8000_0ABC,32'hC000_0000,1'b0,3'd0,4'd4,16'h0015,32'hC000_0ABC,4'd8,32'h4000_0010}, // R7
    '{2'd0,4'd0,2'd1,1'b1,1'b0,4'h0,32'h0,32'h0,          1'b0,3'd0,4'd5, 16'h0035,32'h0,4'd8, 32'h4000_0010},  // R5
    '{2'd2,4'd0,2'd0,1'b1,1'b0,4'hE,32'h0,32'h0,          1'b0,3'd0,4'd3, 16'h0035,32'h0,4'd8, 32'h4000_0010},  // R9
    '{2'd0,4'd0,2'd1,1'b1,1'b0,4'h0,32'h0,32'h0000_0200,  1'b0,3'd1,4'd4, 16'h0035,32'h0,4'd3, 32'h200},        // R6 spill 4
    '{2'd0,4'd0,2'd1,1'b1,1'b0,4'h0,32'h0,32'h0000_0300,  1'b0,3'd3,4'd5, 16'h0035,32'h0,4'd4, 32'h300},        // R6 spill 12
    '{2'd2,4'd0,2'd0,1'b1,1'b0,4'h7,32'h0,32'h0,          1'b0,3'd0,4'd12,16'h0035,32'h0,4'd4, 32'h300},        // R9
    '{2'd1,4'd0,2'd0,1'b1,1'b0,4'h0,32'h4000_0000,32'h0,  1'b0,3'd5,4'd11,16'h0035,32'h0,4'd12,32'h0},          // R8 fill 4
    '{2'd1,4'd0,2'd0,1'b1,1'b0,4'h0,32'hC000_0000,32'h0,  1'b0,3'd7,4'd8, 16'h0035,32'h0,4'd11,32'h0}           // R8 fill 12
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 base", 32'(win_base), 32'd0);
    chk("R1 mask", 32'(live_mask), 32'h0001);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 old_base", 32'(old_base), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NSTEP; i++) begin
      in_valid = 1'b1;
      op       = STEPS[i].op;
      reg_sel  = STEPS[i].sel;
      call_inc = STEPS[i].inc;
      woe      = STEPS[i].woe;
      excm     = STEPS[i].excm;
      rot_imm  = STEPS[i].imm;
      ret_addr = STEPS[i].ra;
      pc       = STEPS[i].pc;
      @(negedge clk);
      $display("step %0d", i);
      chk("R2 done", 32'(done), 32'd1);
      chk("R3 R4 illegal", 32'(illegal), 32'(STEPS[i].e_ill));
      chk("R6 R8 exc_code", 32'(exc_code), 32'(STEPS[i].e_exc));
      chk("R5 R9 base", 32'(win_base), 32'(STEPS[i].e_base));
      chk("R5 R7 mask", 32'(live_mask), 32'(STEPS[i].e_mask));
      chk("R7 ret_pc", ret_pc, STEPS[i].e_ret);
      chk("R10 old_base", 32'(old_base), 32'(STEPS[i].e_owb));
      chk("R10 exc_pc", exc_pc, STEPS[i].e_epc);
    end

    // R2: idle cycle after the last request
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2 idle done", 32'(done), 32'd0);
    chk("R2 idle base", 32'(win_base), 32'd8);

    // R9: rotate by -1 from base 8 lands on 7
    in_valid = 1'b1;
    op = 2'd2;
    rot_imm = 4'hF;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 minus one", 32'(win_base), 32'd7);
    chk("R9 mask kept", 32'(live_mask), 32'h0035);

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset base", 32'(win_base), 32'd0);
    chk("R1 re-reset mask", 32'(live_mask), 32'h0001);
    chk("R1 re-reset exc_pc", exc_pc, 32'd0);
    chk("R1 re-reset done", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule